// File: doc/BRIEF.md
# Tagged Page-Translation Cache

This block is a small fully associative cache of page-to-frame translations. Every stored entry holds a virtual page number, the frame number it maps to, and the tag of the address space that owns it. A lookup presents a page number and the current address-space tag. All entries are compared at once, and one cycle later the block reports either a hit with the frame number or a miss. On a miss, the walker outside this block resolves the translation and writes it back through the fill port.

Because entries carry an address-space tag, translations from several processes can be held at the same time. Entries written with the pin flag set are never picked as replacement victims, so mappings that must always be present stay resident. A tag-less mode drops the tag from the comparison. In that mode, a page-table switch invalidates every unpinned entry. A soft flush removes unpinned entries, and a hard flush removes everything.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, including pinned ones, and `lk_hit`, `lk_miss`, `lk_pfn` and `fill_err` are all 0.
- R2: A request with `lk_req` high in cycle n produces exactly one of `lk_hit` or `lk_miss` high in cycle n+1. Both stay low in any cycle that follows a cycle without a request.
- R3: With `asid_mode`=1, a hit needs a valid entry whose page number and address-space tag both equal the request. `lk_pfn` then carries that entry's frame number.
- R4: With `asid_mode`=0, the tag takes no part in matching. The tag also takes no part in the duplicate check made on fill.
- R5: A filled entry is seen by lookups issued in the cycle after the fill and later. A lookup issued in the same cycle as the fill sees the old contents.
- R6: A fill whose page number and tag (tag only when `asid_mode`=1) match a valid entry rewrites that entry in place. No second copy is created and the replacement pointer does not move.
- R7: Any other fill goes to the first slot, searching circularly from the round-robin pointer, that is not both valid and pinned. The pointer then moves to the slot after it. The pointer starts at slot 0.
- R8: A new fill that finds every slot valid and pinned is dropped. `fill_err` is high for exactly the cycle after it.
- R9: `flush` invalidates every unpinned entry and keeps pinned ones. A fill in the same cycle as `flush`, `flush_all` or an effective `pt_switch` is discarded without raising `fill_err`.
- R10: `flush_all` invalidates every entry, pinned ones included.
- R11: `pt_switch` acts as `flush` when `asid_mode`=0 and has no effect when `asid_mode`=1.
- R12: `lk_pfn` is 0 in every cycle where `lk_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| asid_mode | input | 1 | 1: compare address-space tags; 0: tag-less |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_hit | output | 1 | Registered hit |
| lk_miss | output | 1 | Registered miss |
| lk_pfn | output | PFN_W | Frame number on hit, else 0 |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Page number to write |
| fill_asid | input | ASID_W | Tag to write |
| fill_pfn | input | PFN_W | Frame number to write |
| fill_pin | input | 1 | Pin the written entry |
| fill_err | output | 1 | Fill dropped because every slot is pinned |
| flush | input | 1 | Invalidate unpinned entries |
| flush_all | input | 1 | Invalidate all entries |
| pt_switch | input | 1 | Page-table change; flushes unpinned entries in tag-less mode |

## Verification
The uniqueness property, which says that at most one entry matches any lookup, only holds when `asid_mode` has not changed since the last `flush_all`. Entries written under tag compare can alias once tags are ignored. The check is therefore armed only while the mode has been stable since a hard flush. The stimulus changes `asid_mode` only in the same cycle as `flush_all`. It keeps page numbers and tags within small sets so that overwrites, evictions and fully pinned arrays occur often.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  // slot reached by stepping 'step' places from 'base' on a ring of n slots
  function automatic int ring_slot(input int base, input int step, input int n);
    int s;
    s = base + step;
    if (s >= n) s = s - n;
    return s;
  endfunction

  // slot following 'idx' on a ring of n slots
  function automatic int ring_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [N-1:0]      valid,
  input  logic [VPN_W-1:0]  ent_vpn  [N],
  input  logic [ASID_W-1:0] ent_asid [N],
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  input  logic              use_asid,
  output logic [N-1:0]      hit_vec,
  output logic              any_hit,
  output logic [IDX_W-1:0]  hit_idx
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = valid[i] && (ent_vpn[i] == key_vpn) &&
                        (!use_asid || (ent_asid[i] == key_asid));
  end

  assign any_hit = |hit_vec;

  // lowest matching slot wins
  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     locked,
  input  logic [IDX_W-1:0] start,
  output logic             found,
  output logic [IDX_W-1:0] victim
);
  import asid_tlb_pkg::*;

  // first unlocked slot searching circularly from start
  always_comb begin
    int s;
    found  = 1'b0;
    victim = start;
    for (int k = N - 1; k >= 0; k--) begin
      s = ring_slot(int'(start), k, N);
      if (!locked[s]) begin
        found  = 1'b1;
        victim = IDX_W'(s);
      end
    end
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              asid_mode,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PFN_W-1:0]  lk_pfn,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_pin,
  output logic              fill_err,
  input  logic              flush,
  input  logic              flush_all,
  input  logic              pt_switch
);
  import asid_tlb_pkg::*;

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      valid, pin, valid_nxt, pin_nxt, locked;
  logic [VPN_W-1:0]  e_vpn  [N];
  logic [ASID_W-1:0] e_asid [N];
  logic [PFN_W-1:0]  e_pfn  [N];
  logic [IDX_W-1:0]  rr_ptr;

  // named internal events
  logic [N-1:0]      look_vec, dup_vec;
  logic              look_any, dup_any, vic_found;
  logic [IDX_W-1:0]  look_idx, dup_idx, vic_idx, wr_idx;
  logic              kill_soft, fill_go, wr_en, wr_new, fill_drop;

  assign locked    = valid & pin;
  assign kill_soft = flush | (pt_switch & ~asid_mode);
  assign fill_go   = fill_en & ~kill_soft & ~flush_all;
  assign wr_en     = fill_go & (dup_any | vic_found);
  assign wr_new    = wr_en & ~dup_any;
  assign fill_drop = fill_go & ~dup_any & ~vic_found;
  assign wr_idx    = dup_any ? dup_idx : vic_idx;

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_look (
    .valid(valid), .ent_vpn(e_vpn), .ent_asid(e_asid),
    .key_vpn(lk_vpn), .key_asid(lk_asid), .use_asid(asid_mode),
    .hit_vec(look_vec), .any_hit(look_any), .hit_idx(look_idx)
  );

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_dup (
    .valid(valid), .ent_vpn(e_vpn), .ent_asid(e_asid),
    .key_vpn(fill_vpn), .key_asid(fill_asid), .use_asid(asid_mode),
    .hit_vec(dup_vec), .any_hit(dup_any), .hit_idx(dup_idx)
  );

  tlb_victim #(.N(N), .IDX_W(IDX_W)) u_vic (
    .locked(locked), .start(rr_ptr), .found(vic_found), .victim(vic_idx)
  );

  always_comb begin
    valid_nxt = valid;
    pin_nxt   = pin;
    if (flush_all) begin
      valid_nxt = '0;
      pin_nxt   = '0;
    end else if (kill_soft) begin
      valid_nxt = valid & pin;
    end else if (wr_en) begin
      valid_nxt[wr_idx] = 1'b1;
      pin_nxt[wr_idx]   = fill_pin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= '0;
      pin      <= '0;
      rr_ptr   <= '0;
      lk_hit   <= 1'b0;
      lk_miss  <= 1'b0;
      lk_pfn   <= '0;
      fill_err <= 1'b0;
    end else begin
      valid    <= valid_nxt;
      pin      <= pin_nxt;
      lk_hit   <= lk_req & look_any;
      lk_miss  <= lk_req & ~look_any;
      lk_pfn   <= (lk_req & look_any) ? e_pfn[look_idx] : '0;
      fill_err <= fill_drop;
      if (wr_new) rr_ptr <= IDX_W'(ring_next(int'(vic_idx), N));
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_vpn[wr_idx]  <= fill_vpn;
      e_asid[wr_idx] <= fill_asid;
      e_pfn[wr_idx]  <= fill_pfn;
    end
  end

  // ---------------- assertion support ----------------
  logic seen, mode_q, mode_clean;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen       <= 1'b0;
      mode_q     <= 1'b0;
      mode_clean <= 1'b0;
    end else begin
      seen   <= 1'b1;
      mode_q <= asid_mode;
      if (flush_all) mode_clean <= 1'b1;
      else if (seen && asid_mode != mode_q) mode_clean <= 1'b0;
    end
  end

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((lk_hit || lk_miss) == $past(lk_req)));
  a_r6_unique: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_clean && seen && asid_mode == mode_q) |-> $onehot0(look_vec));
  a_r8_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && fill_err) |-> ($past(fill_en) && (&$past(locked))));
  a_r9_pinned_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(flush) && !$past(flush_all)) |-> (locked == $past(locked)));
  a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(flush_all)) |-> (valid == '0));
  a_r12_pfn_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pfn == '0));

endmodule

// File: tb/asid_tlb_tb.sv
`timescale 1ns/1ps
module asid_tlb_tb_top;
  localparam int N = 8, VPN_W = 20, ASID_W = 8, PFN_W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic asid_mode = 1'b1;
  logic lk_req = 1'b0, fill_en = 1'b0, fill_pin = 1'b0;
  logic flush = 1'b0, flush_all = 1'b0, pt_switch = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [ASID_W-1:0] lk_asid = '0, fill_asid = '0;
  logic [PFN_W-1:0] fill_pfn = '0, lk_pfn;
  logic lk_hit, lk_miss, fill_err;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  asid_tlb #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .asid_mode(asid_mode),
    .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .fill_pin(fill_pin), .fill_err(fill_err),
    .flush(flush), .flush_all(flush_all), .pt_switch(pt_switch)
  );

  // behavioural reference
  bit m_v [N];
  bit m_p [N];
  int m_vpn [N];
  int m_asid [N];
  int m_pfn [N];
  int m_rr;

  function automatic bit same_key(int i, int vpn, int asid);
    return m_v[i] && m_vpn[i] == vpn && (!asid_mode || m_asid[i] == asid);
  endfunction

  task automatic check(string tag, bit e_hit, bit e_miss, int e_pfn, bit e_err);
    tests++;
    if (lk_hit !== e_hit || lk_miss !== e_miss || lk_pfn !== PFN_W'(e_pfn) || fill_err !== e_err) begin
      fails++;
      $display("FAIL %s: hit/miss/pfn/err = %0b/%0b/%0h/%0b expected %0b/%0b/%0h/%0b",
               tag, lk_hit, lk_miss, lk_pfn, fill_err, e_hit, e_miss, e_pfn, e_err);
    end
  endtask

  // apply current inputs for one clock, update model, compare
  task automatic step(string tag);
    bit e_hit, e_miss, e_err, done;
    int e_pfn, dup, slot;
    e_hit = 0; e_miss = 0; e_err = 0; e_pfn = 0;
    if (lk_req) begin
      done = 0;
      for (int i = 0; i < N; i++)
        if (!done && same_key(i, int'(lk_vpn), int'(lk_asid))) begin
          e_hit = 1; e_pfn = m_pfn[i]; done = 1;
        end
      e_miss = !e_hit;
    end
    if (flush_all) begin
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_p[i] = 0; end
    end else if (flush || (pt_switch && !asid_mode)) begin
      for (int i = 0; i < N; i++) if (!m_p[i]) m_v[i] = 0;
    end else if (fill_en) begin
      dup = -1;
      for (int i = N - 1; i >= 0; i--) if (same_key(i, int'(fill_vpn), int'(fill_asid))) dup = i;
      if (dup < 0) begin
        for (int k = N - 1; k >= 0; k--) if (!(m_v[(m_rr + k) % N] && m_p[(m_rr + k) % N])) dup = -2 - ((m_rr + k) % N);
        if (dup == -1) e_err = 1;
        else begin slot = -2 - dup; m_rr = (slot + 1) % N; dup = slot; end
      end
      if (!e_err) begin
        m_v[dup] = 1; m_p[dup] = fill_pin; m_vpn[dup] = int'(fill_vpn);
        m_asid[dup] = int'(fill_asid); m_pfn[dup] = int'(fill_pfn);
      end
    end
    @(posedge clk); @(negedge clk);
    check(tag, e_hit, e_miss, e_pfn, e_err);
    lk_req = 0; fill_en = 0; flush = 0; flush_all = 0; pt_switch = 0; fill_pin = 0;
  endtask

  task automatic look(int vpn, int asid, string tag);
    lk_req = 1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid); step(tag);
  endtask

  task automatic put(int vpn, int asid, int pfn, bit p);
    fill_en = 1; fill_vpn = VPN_W'(vpn); fill_asid = ASID_W'(asid);
    fill_pfn = PFN_W'(pfn); fill_pin = p;
  endtask

  initial begin
    #1_000_000;
    fails++; tests++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_p[i] = 0; m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0; end
    m_rr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset outputs", 0, 0, 0, 0);
    look(5, 1, "R1 empty after reset");
    step("R2 no request, no result");

    // tag compare mode
    put(5, 1, 'h100, 0); lk_req = 1; lk_vpn = 5; lk_asid = 1; step("R5 same-cycle lookup sees old");
    look(5, 1, "R5 R3 hit after fill");
    look(5, 2, "R3 other tag misses");
    put(5, 2, 'h200, 0); step("R3 fill second tag");
    look(5, 2, "R3 second tag hit");
    look(5, 1, "R3 first tag still hit");
    put(5, 1, 'h111, 0); step("R6 overwrite");
    look(5, 1, "R6 rewritten value");
    put(6, 1, 'h600, 0); step("R7 next slot");
    look(6, 1, "R7 hit new slot");

    // tag-less mode
    flush_all = 1; asid_mode = 0; step("R10 hard flush");
    look(5, 2, "R10 gone after hard flush");
    put(9, 3, 'h99, 0); step("R4 fill");
    look(9, 7, "R4 tag ignored");
    put(9, 4, 'h98, 0); step("R4 R6 dedupe without tag");
    look(9, 0, "R4 single rewritten entry");

    // pinning and round robin
    put(1, 0, 'h11, 1); step("R7 pinned fill");
    put(2, 0, 'h22, 1); step("R7 pinned fill");
    for (int v = 20; v < 32; v++) begin put(v, 0, 'h1000 + v, 0); step("R7 churn"); end
    look(1, 0, "R7 pinned survives");
    look(2, 0, "R7 pinned survives");
    look(20, 0, "R7 oldest evicted");
    look(31, 0, "R7 newest present");
    pt_switch = 1; step("R11 switch in tag-less mode");
    look(31, 0, "R11 unpinned cleared");
    look(1, 0, "R11 pinned kept");

    // back to tag mode
    flush_all = 1; asid_mode = 1; step("R10 hard flush");
    put(3, 5, 'h33, 0); step("R11 fill");
    pt_switch = 1; step("R11 switch in tag mode");
    look(3, 5, "R11 no effect in tag mode");
    put(4, 5, 'h44, 0); flush = 1; step("R9 fill during flush dropped");
    look(4, 5, "R9 dropped fill absent");
    look(3, 5, "R9 unpinned flushed");
    put(8, 5, 'h88, 1); step("R9 pin"); flush = 1; step("R9 flush");
    look(8, 5, "R9 pinned kept");

    // full of pinned entries
    for (int v = 40; v < 40 + N; v++) begin put(v, 1, v, 1); step("R8 pin fill"); end
    put(77, 1, 'h77, 0); step("R8 fill dropped");
    step("R8 error is one cycle");
    look(77, 1, "R8 dropped fill absent");
    put(45, 1, 'h45, 1); step("R6 overwrite when full");
    look(45, 1, "R6 overwrite when full");
    flush_all = 1; step("R10 clears pinned");
    look(40, 1, "R10 pinned gone");

    // mixed traffic
    for (int c = 0; c < 400; c++) begin
      if (c == 200) begin flush_all = 1; asid_mode = 0; step("R10 mode change"); end
      lk_req = 1'($urandom % 2); lk_vpn = VPN_W'($urandom % 6); lk_asid = ASID_W'($urandom % 3);
      if ($urandom % 3 == 0) put($urandom % 6, $urandom % 3, $urandom % 4096, ($urandom % 6) == 0);
      flush = ($urandom % 20) == 0;
      pt_switch = ($urandom % 20) == 0;
      flush_all = ($urandom % 40) == 0;
      step("R12 R2 mixed traffic");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule